// File: doc/BRIEF.md
# Core Power-Up/Power-Down Sequencer

This block steps one of up to four processor cores through a power transition on command. A request carries a start pulse, a direction flag (on or off), a request identifier whose two low bits select the core, and a boot address that the block latches and presents on its output for the woken core to fetch. For each core it owns a 2-bit reset field, an L1-invalidate bit, a debug-access enable bit, a power-gating bit and an 8-bit power-clamp value. Only the selected core's controls change during a sequence.

Power-on holds the core in reset, clears its invalidate bit and locks debug access. It then opens the clamp one bit per cycle, waits a settle time measured in milliseconds of an external counter, removes power gating, releases reset and unlocks debug. Power-off first waits for the core to report wait-for-interrupt, sampling that flag on entry and then once per elapsed millisecond. It then holds the core in reset, locks debug, gates power, closes the clamp and unlocks debug. A one-cycle done pulse closes every sequence.

States: IDLE, ON_HOLD, ON_FLUSH, ON_LOCK, ON_RAMP, ON_SETTLE, ON_UNGATE, ON_RELEASE, ON_UNLOCK, OFF_POLL, OFF_HOLD, OFF_LOCK, OFF_GATE, OFF_CLAMP, OFF_UNLOCK. Transitions: IDLE to ON_HOLD on an accepted start with the direction flag high, IDLE to OFF_POLL on an accepted start with it low. Each ON and OFF step state except ON_RAMP, ON_SETTLE and OFF_POLL advances unconditionally to the next one listed. ON_RAMP goes to ON_SETTLE after the write of 0x00. ON_SETTLE goes to ON_UNGATE when the last settle millisecond ends. OFF_POLL goes to OFF_HOLD when a sample finds the core waiting. ON_UNLOCK and OFF_UNLOCK return to IDLE.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset every core has reset field 2'b00 (held), L1-invalidate 1, debug enable 1, power gating 1 and clamp 0xFF; busy and done are 0.
- R2: The target core is bits [1:0] of the request identifier; upper identifier bits have no effect.
- R3: A start is accepted only when busy is low; a start while busy changes no output, including the latched address.
- R4: The entry address is latched at acceptance and is visible on the output in the cycle after the accepting edge.
- R5: Counting the accepting edge as edge 0, power-on writes reset 2'b00 at edge 1, invalidate 0 at edge 2, debug 0 at edge 3. It then writes gating 0 at edge T+1, reset 2'b11 at edge T+2 and debug 1 at edge T+3, where T = 12 + SETTLE_MS*CNT_FREQ/1000.
- R6: The clamp ramp writes 0xFF, 0x7F, 0x3F, 0x1F, 0x0F, 0x07, 0x03, 0x01, 0x00 at edges 4 to 12, each held one cycle.
- R7: After the zero clamp write the block waits SETTLE_MS*CNT_FREQ/1000 counter ticks before removing power gating.
- R8: Power-off samples the core's WFI flag at edge 1 and after that only at edges that complete a millisecond (every CNT_FREQ/1000 ticks after acceptance); a WFI high between samples is ignored.
- R9: With WFI found at edge p, power-off writes reset 2'b00 at p+1, debug 0 at p+2, gating 1 at p+3, clamp 0xFF at p+4 and debug 1 at p+5.
- R10: Busy is high from the cycle after acceptance until the final write; done is high for exactly the one cycle after the final write.
- R11: Outputs of cores other than the selected one never change during a sequence.
- R12: A core's power gating is never 0 while its clamp is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse |
| power_on_i | input | 1 | 1 = power the core up, 0 = power it down |
| req_id_i | input | ID_W | Request identifier; low bits select the core |
| entry_addr_i | input | ADDR_W | Boot address for a power-on request |
| ctr_tick_i | input | 1 | One pulse per counter increment |
| core_wfi_i | input | NUM_CORES | Per-core wait-for-interrupt status |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| entry_addr_o | output | ADDR_W | Latched boot address |
| core_rst_o | output | 2*NUM_CORES | Per-core reset field, 2'b00 held, 2'b11 released |
| l1_inv_o | output | NUM_CORES | Per-core L1-invalidate control |
| dbg_en_o | output | NUM_CORES | Per-core debug-access enable |
| pwr_gate_o | output | NUM_CORES | Per-core power gating, 1 = gated |
| clamp_o | output | 8*NUM_CORES | Per-core power-clamp value |

## Verification
Two events can land on the same edge. A new start can arrive on the edge where the block writes its final step and raises done. A WFI rise can coincide with, or narrowly miss, the millisecond sample edge. The bench drives a start exactly on the final-step edge and expects it to be dropped, with busy low and nothing moving afterwards. It also raises WFI only between sample edges, then exactly before one, and compares every output in every cycle against a model whose event edges are computed from the tick period and the settle count.

// File: rtl/core_pwr_pkg.sv
package core_pwr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ON_HOLD,
        ST_ON_FLUSH,
        ST_ON_LOCK,
        ST_ON_RAMP,
        ST_ON_SETTLE,
        ST_ON_UNGATE,
        ST_ON_RELEASE,
        ST_ON_UNLOCK,
        ST_OFF_POLL,
        ST_OFF_HOLD,
        ST_OFF_LOCK,
        ST_OFF_GATE,
        ST_OFF_CLAMP,
        ST_OFF_UNLOCK
    } seq_state_e;

    typedef struct packed {
        logic       wr_rst;
        logic [1:0] rst_val;
        logic       wr_inv;
        logic       inv_val;
        logic       wr_dbg;
        logic       dbg_val;
        logic       wr_gate;
        logic       gate_val;
        logic       wr_clamp;
        logic [7:0] clamp_val;
    } core_wr_t;

    localparam logic [1:0] RST_HELD   = 2'b00;
    localparam logic [1:0] RST_RUN    = 2'b11;
    localparam logic [7:0] CLAMP_SHUT = 8'hFF;

endpackage

// File: rtl/cps_ms_timer.sv
module cps_ms_timer #(
    parameter int CYC_PER_MS = 24000,
    parameter int SETTLE_MS  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic ms_pulse,
    output logic settle_done
);
    localparam int CW = $clog2(CYC_PER_MS + 1);
    localparam int MW = $clog2(SETTLE_MS + 1);

    logic [CW-1:0] cyc_q;
    logic [MW-1:0] ms_q;

    assign ms_pulse    = tick && !clr && (cyc_q == CW'(CYC_PER_MS - 1));
    assign settle_done = ms_pulse && (ms_q == MW'(SETTLE_MS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
            ms_q  <= '0;
        end else if (clr) begin
            cyc_q <= '0;
            ms_q  <= '0;
        end else if (tick) begin
            cyc_q <= ms_pulse ? '0 : cyc_q + 1'b1;
            if (ms_pulse) ms_q <= ms_q + 1'b1;
        end
    end

    AST_CYC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_q < CW'(CYC_PER_MS)); // R7

endmodule

// File: rtl/cps_clamp_ramp.sv
module cps_clamp_ramp (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       shift,
    output logic [7:0] step_val,
    output logic       last
);
    logic [8:0] sh_q;

    assign step_val = sh_q[8:1];
    assign last     = (sh_q[8:1] == 8'h00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sh_q <= '0;
        else if (load)  sh_q <= 9'h1FF;
        else if (shift) sh_q <= {1'b0, sh_q[8:1]};
    end

endmodule

// File: rtl/cps_core_ctl.sv
module cps_core_ctl
    import core_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  core_wr_t   wr,
    output logic [1:0] rst_fld,
    output logic       inv,
    output logic       dbg,
    output logic       gate,
    output logic [7:0] clamp
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_fld <= RST_HELD;
            inv     <= 1'b1;
            dbg     <= 1'b1;
            gate    <= 1'b1;
            clamp   <= CLAMP_SHUT;
        end else if (sel) begin
            if (wr.wr_rst)   rst_fld <= wr.rst_val;
            if (wr.wr_inv)   inv     <= wr.inv_val;
            if (wr.wr_dbg)   dbg     <= wr.dbg_val;
            if (wr.wr_gate)  gate    <= wr.gate_val;
            if (wr.wr_clamp) clamp   <= wr.clamp_val;
        end
    end

endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
    import core_pwr_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 32,
    parameter int ID_W      = 8,
    parameter int CNT_FREQ  = 24_000_000,
    parameter int SETTLE_MS = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   power_on_i,
    input  logic [ID_W-1:0]        req_id_i,
    input  logic [ADDR_W-1:0]      entry_addr_i,
    input  logic                   ctr_tick_i,
    input  logic [NUM_CORES-1:0]   core_wfi_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [ADDR_W-1:0]      entry_addr_o,
    output logic [2*NUM_CORES-1:0] core_rst_o,
    output logic [NUM_CORES-1:0]   l1_inv_o,
    output logic [NUM_CORES-1:0]   dbg_en_o,
    output logic [NUM_CORES-1:0]   pwr_gate_o,
    output logic [8*NUM_CORES-1:0] clamp_o
);
    localparam int IDX_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
    localparam int CYC_RAW    = CNT_FREQ / 1000;
    localparam int CYC_PER_MS = (CYC_RAW < 1) ? 1 : CYC_RAW;

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] core_q;
    logic             poll_first_q;
    logic             done_q;
    logic [ADDR_W-1:0] entry_q;

    core_wr_t wr;
    logic     ramp_load, ramp_shift, finish;
    logic     timer_clr, ms_pulse, settle_done;
    logic [7:0] ramp_val;
    logic       ramp_last;
    logic       accept;

    logic [1:0] rst_a   [NUM_CORES];
    logic       inv_a   [NUM_CORES];
    logic       dbg_a   [NUM_CORES];
    logic       gate_a  [NUM_CORES];
    logic [7:0] clamp_a [NUM_CORES];

    logic unused_id_bits;
    assign unused_id_bits = ^req_id_i;

    assign accept       = start_i && (state_q == ST_IDLE);
    assign busy_o       = (state_q != ST_IDLE);
    assign done_o       = done_q;
    assign entry_addr_o = entry_q;
    assign timer_clr    = !((state_q == ST_ON_SETTLE) || (state_q == ST_OFF_POLL));

    // State register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            core_q       <= '0;
            entry_q      <= '0;
            poll_first_q <= 1'b0;
            done_q       <= 1'b0;
        end else begin
            state_q      <= state_d;
            poll_first_q <= accept;
            done_q       <= finish;
            if (accept) begin
                core_q  <= req_id_i[IDX_W-1:0];
                entry_q <= entry_addr_i;
            end
        end
    end

    // Next state and per-step write strobes
    always_comb begin
        state_d    = state_q;
        wr         = '0;
        ramp_load  = 1'b0;
        ramp_shift = 1'b0;
        finish     = 1'b0;
        unique case (state_q)
            ST_IDLE:
                if (start_i) state_d = power_on_i ? ST_ON_HOLD : ST_OFF_POLL;
            ST_ON_HOLD: begin
                wr.wr_rst = 1'b1; wr.rst_val = RST_HELD;
                state_d = ST_ON_FLUSH;
            end
            ST_ON_FLUSH: begin
                wr.wr_inv = 1'b1; wr.inv_val = 1'b0;
                state_d = ST_ON_LOCK;
            end
            ST_ON_LOCK: begin
                wr.wr_dbg = 1'b1; wr.dbg_val = 1'b0;
                ramp_load = 1'b1;
                state_d = ST_ON_RAMP;
            end
            ST_ON_RAMP: begin
                wr.wr_clamp = 1'b1; wr.clamp_val = ramp_val;
                ramp_shift = 1'b1;
                if (ramp_last) state_d = ST_ON_SETTLE;
            end
            ST_ON_SETTLE:
                if (settle_done) state_d = ST_ON_UNGATE;
            ST_ON_UNGATE: begin
                wr.wr_gate = 1'b1; wr.gate_val = 1'b0;
                state_d = ST_ON_RELEASE;
            end
            ST_ON_RELEASE: begin
                wr.wr_rst = 1'b1; wr.rst_val = RST_RUN;
                state_d = ST_ON_UNLOCK;
            end
            ST_ON_UNLOCK: begin
                wr.wr_dbg = 1'b1; wr.dbg_val = 1'b1;
                finish = 1'b1;
                state_d = ST_IDLE;
            end
            ST_OFF_POLL:
                if ((poll_first_q || ms_pulse) && core_wfi_i[core_q]) state_d = ST_OFF_HOLD;
            ST_OFF_HOLD: begin
                wr.wr_rst = 1'b1; wr.rst_val = RST_HELD;
                state_d = ST_OFF_LOCK;
            end
            ST_OFF_LOCK: begin
                wr.wr_dbg = 1'b1; wr.dbg_val = 1'b0;
                state_d = ST_OFF_GATE;
            end
            ST_OFF_GATE: begin
                wr.wr_gate = 1'b1; wr.gate_val = 1'b1;
                state_d = ST_OFF_CLAMP;
            end
            ST_OFF_CLAMP: begin
                wr.wr_clamp = 1'b1; wr.clamp_val = CLAMP_SHUT;
                state_d = ST_OFF_UNLOCK;
            end
            ST_OFF_UNLOCK: begin
                wr.wr_dbg = 1'b1; wr.dbg_val = 1'b1;
                finish = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    cps_ms_timer #(
        .CYC_PER_MS (CYC_PER_MS),
        .SETTLE_MS  (SETTLE_MS)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (timer_clr),
        .tick        (ctr_tick_i),
        .ms_pulse    (ms_pulse),
        .settle_done (settle_done)
    );

    cps_clamp_ramp u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ramp_load),
        .shift    (ramp_shift),
        .step_val (ramp_val),
        .last     (ramp_last)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        cps_core_ctl u_ctl (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (core_q == IDX_W'(c)),
            .wr      (wr),
            .rst_fld (rst_a[c]),
            .inv     (inv_a[c]),
            .dbg     (dbg_a[c]),
            .gate    (gate_a[c]),
            .clamp   (clamp_a[c])
        );
        assign core_rst_o[2*c +: 2] = rst_a[c];
        assign l1_inv_o[c]          = inv_a[c];
        assign dbg_en_o[c]          = dbg_a[c];
        assign pwr_gate_o[c]        = gate_a[c];
        assign clamp_o[8*c +: 8]    = clamp_a[c];

        AST_GATE_NEEDS_OPEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
            !gate_a[c] |-> (clamp_a[c] == 8'h00)); // R12

        AST_GATE_MOVES_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(gate_a[c]) |-> (rst_a[c] == RST_HELD)); // R5

        AST_OTHER_CORES_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_o && (core_q != IDX_W'(c))) |=>
                ($stable(rst_a[c]) && $stable(gate_a[c]) && $stable(clamp_a[c])
                 && $stable(dbg_a[c]) && $stable(inv_a[c]))); // R11
    end

    logic [7:0] sel_clamp;
    assign sel_clamp = clamp_a[core_q];

    AST_RAMP_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_ON_RAMP && $past(state_q, 2) == ST_ON_RAMP)
            |-> (sel_clamp == ($past(sel_clamp) >> 1))); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R3

    AST_ADDR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(entry_addr_o)); // R4

endmodule

// File: tb/core_pwr_seq_tb_top.sv
module core_pwr_seq_tb_top;
    localparam int N          = 4;
    localparam int AW         = 32;
    localparam int IDW        = 8;
    localparam int FREQ       = 4000;
    localparam int CYC        = FREQ / 1000;
    localparam int SMS        = 10;
    localparam int CLK_PERIOD = 10;
    localparam int T_SET      = 12 + SMS * CYC;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            power_on = 1'b0;
    logic [IDW-1:0]  req_id = '0;
    logic [AW-1:0]   entry_addr = '0;
    logic            ctr_tick = 1'b1;
    logic [N-1:0]    core_wfi = '0;
    logic            busy, done;
    logic [AW-1:0]   entry_out;
    logic [2*N-1:0]  core_rst;
    logic [N-1:0]    l1_inv, dbg_en, pwr_gate;
    logic [8*N-1:0]  clamp;

    core_pwr_seq #(
        .NUM_CORES (N), .ADDR_W (AW), .ID_W (IDW),
        .CNT_FREQ (FREQ), .SETTLE_MS (SMS)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .start_i (start), .power_on_i (power_on),
        .req_id_i (req_id), .entry_addr_i (entry_addr), .ctr_tick_i (ctr_tick),
        .core_wfi_i (core_wfi), .busy_o (busy), .done_o (done),
        .entry_addr_o (entry_out), .core_rst_o (core_rst), .l1_inv_o (l1_inv),
        .dbg_en_o (dbg_en), .pwr_gate_o (pwr_gate), .clamp_o (clamp)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [1:0]    m_rst   [N];
    logic          m_inv   [N];
    logic          m_dbg   [N];
    logic          m_gate  [N];
    logic [7:0]    m_clamp [N];
    logic [AW-1:0] m_entry;
    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_cores(int sel, string tag);
        for (int c = 0; c < N; c++) begin
            logic [12:0] act, exp;
            act = {core_rst[2*c +: 2], l1_inv[c], dbg_en[c], pwr_gate[c], clamp[8*c +: 8]};
            exp = {m_rst[c], m_inv[c], m_dbg[c], m_gate[c], m_clamp[c]};
            chk(act == exp, (c == sel) ? tag : "R11", $sformatf("core%0d ctl", c), act, exp);
            chk(pwr_gate[c] || clamp[8*c +: 8] == 8'h00, "R12",
                $sformatf("core%0d gate/clamp", c), {pwr_gate[c], clamp[8*c +: 8]}, 0);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_seq(int core, bit on, logic [AW-1:0] addr,
                           int wfi_at, int glo, int ghi, int intr_k);
        int p, end_k;
        string tag;
        p = (wfi_at <= 1) ? 1 : ((wfi_at + CYC - 1) / CYC) * CYC;
        end_k = on ? T_SET + 3 : p + 5;
        start = 1'b1;
        power_on = on;
        req_id = IDW'(core | (((core * 5 + 3) & 63) << 2));
        entry_addr = addr;
        cyc();
        start = 1'b0;
        m_entry = addr;
        chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
        chk(entry_out == m_entry, "R4", "entry addr latch", entry_out, m_entry);
        for (int k = 1; k <= end_k + 1; k++) begin
            core_wfi[core] = !on && ((k >= wfi_at) || (k >= glo && k <= ghi));
            if (k == intr_k) begin
                start = 1'b1;
                power_on = !on;
                req_id = IDW'((core + 1) % N);
                entry_addr = ~addr;
            end
            cyc();
            start = 1'b0;
            if (on) begin
                if (k == 1) m_rst[core] = 2'b00;
                if (k == 2) m_inv[core] = 1'b0;
                if (k == 3) m_dbg[core] = 1'b0;
                if (k >= 4 && k <= 12) m_clamp[core] = 8'hFF >> (k - 4);
                if (k == T_SET + 1) m_gate[core] = 1'b0;
                if (k == T_SET + 2) m_rst[core] = 2'b11;
                if (k == T_SET + 3) m_dbg[core] = 1'b1;
                tag = (k == 1) ? "R2/R5" : (k <= 3) ? "R5" : (k <= 12) ? "R6" :
                      (k <= T_SET + 1) ? "R7" : "R5";
            end else begin
                if (k == p + 1) m_rst[core] = 2'b00;
                if (k == p + 2) m_dbg[core] = 1'b0;
                if (k == p + 3) m_gate[core] = 1'b1;
                if (k == p + 4) m_clamp[core] = 8'hFF;
                if (k == p + 5) m_dbg[core] = 1'b1;
                tag = (k <= p + 1) ? "R8" : "R9";
            end
            if (intr_k > 0 && k >= intr_k) tag = {tag, "/R3"};
            compare_cores(core, tag);
            chk(busy == (k < end_k), "R10", $sformatf("busy k=%0d", k), busy, k < end_k);
            chk(done == (k == end_k), "R10", $sformatf("done k=%0d", k), done, k == end_k);
            chk(entry_out == m_entry, "R3", "entry addr held", entry_out, m_entry);
        end
        core_wfi = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int c = 0; c < N; c++) begin
            m_rst[c] = 2'b00; m_inv[c] = 1'b1; m_dbg[c] = 1'b1;
            m_gate[c] = 1'b1; m_clamp[c] = 8'hFF;
        end
        m_entry = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        compare_cores(-1, "R1");
        chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done after reset", {busy, done}, 0);

        for (int c = 0; c < N; c++) begin
            int intr;
            intr = (c == 0) ? 5 : (c == 1) ? T_SET + 3 : (c == 2) ? 20 : -1;
            run_seq(c, 1'b1, 32'h8000_0000 + 32'(c * 32'h1_0004), 999, -1, -1, intr);
        end
        // R8/R9: power-off with varied WFI timing
        run_seq(0, 1'b0, 32'h0000_1000, 1, -1, -1, -1);
        run_seq(1, 1'b0, 32'h0000_2000, 6, -1, -1, -1);
        run_seq(2, 1'b0, 32'h0000_3000, 10, 2, 3, -1);
        run_seq(3, 1'b0, 32'h0000_4000, 4, -1, -1, 3);
        // R5: a core powered back on after being powered off
        run_seq(2, 1'b1, 32'hCAFE_0000, 999, -1, -1, -1);
        run_seq(2, 1'b0, 32'hCAFE_0004, 9, 5, 7, 9);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule